// File: doc/BRIEF.md
# Shared Host Interrupt Flag

This block holds one interrupt-request bit that is shared by two masters: a local CPU and an external host port. The CPU raises the bit to signal the host. The host lowers it to acknowledge. Each master writes through its own valid/ready write channel. The block resolves writes that arrive in the same clock cycle. It drives an active-low interrupt pin to the host, and both masters can see the current bit value at all times.

Both write channels work the same way. A write is taken on a rising clock edge when `valid` and `ready` are both high. A master whose `ready` is low must hold `valid` and its data until `ready` returns high; nothing is taken while `ready` is low.

The host channel stays busy for a short, bounded time after each write. The CPU channel is busy only while a deferred set is waiting. When both masters write a 1 to the bit in the same cycle, the host clear is applied first. The CPU set follows one cycle later, so neither event is lost, and neither `ready` stays low for more than two cycles.

Top module: `hif_flag_top`

## Requirements
- R1: After reset the flag is 0, `host_int_n` is 1, and both `host_wr_ready` and `cpu_wr_ready` are 1.
- R2: A CPU write that is taken with data bit `FLAG_BIT` = 1 makes the flag 1 from the next cycle on, unless a host clear is taken in the same cycle.
- R3: A host write that is taken with data bit `FLAG_BIT` = 1 makes the flag 0 from the next cycle on.
- R4: A write from either side with data bit `FLAG_BIT` = 0 leaves the flag unchanged, whatever the other data bits are. A CPU set while the flag is 1 and a host clear while the flag is 0 also leave it unchanged.
- R5: If both masters have a write taken in the same cycle with bit `FLAG_BIT` = 1:
  - the flag is 0 in the next cycle and 1 in the cycle after;
  - `cpu_wr_ready` is low for exactly that first cycle.
- R6: `host_wr_ready` behaves as follows:
  - after a host write that is taken without a collision, it is low for `HOST_BUSY` cycles (1 or 2);
  - after a collision (R5), it is low for 2 cycles;
  - it is never low for more than 2 consecutive cycles.
- R7: A write whose `valid` is high while its `ready` is low is not taken and has no effect on the flag. It is taken at the first edge where `ready` is high.
- R8: `host_int_n` is always the inverse of the flag.
- R9: `host_rdata` and `cpu_rdata` both show the flag at bit `FLAG_BIT` and 0 in every other bit. Reading has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_valid | input | 1 | Host write request |
| host_wr_data | input | DATA_W | Host write data; bit FLAG_BIT = 1 requests clear |
| host_wr_ready | output | 1 | Host write channel can take a write |
| host_rdata | output | DATA_W | Host view of the flag register |
| cpu_wr_valid | input | 1 | CPU write request |
| cpu_wr_data | input | DATA_W | CPU write data; bit FLAG_BIT = 1 requests set |
| cpu_wr_ready | output | 1 | CPU write channel can take a write |
| cpu_rdata | output | DATA_W | CPU view of the flag register |
| host_int_n | output | 1 | Active-low interrupt to the host |

## Verification
The bench builds the block with DATA_W = 16, FLAG_BIT = 3 and HOST_BUSY = 1. This choice makes the plain host busy window (one cycle) differ from the collision busy window (two cycles), so R6 can be checked on both paths.

Bit 3 lies in the middle of the word. Writes with only the neighbouring bits set therefore show that those bits are ignored, and the read views show that they stay 0.

The single-cycle busy window also lets the bench present a write in the cycle where `ready` is low and see it wait for exactly one edge.

// File: rtl/hif_pkg.sv
package hif_pkg;

  // Width of the host busy counter; busy windows never exceed 2 cycles.
  localparam int unsigned BUSY_CNT_W = 2;
  localparam int unsigned MAX_BUSY   = 2;

  typedef logic [BUSY_CNT_W-1:0] busy_cnt_t;

  // How a cycle's write activity resolves against the flag.
  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_SET     = 2'd1,
    ACT_CLEAR   = 2'd2,
    ACT_COLLIDE = 2'd3
  } flag_act_e;

  // Busy window loaded into the host counter after a taken write.
  function automatic busy_cnt_t host_busy_len(input logic collide,
                                              input int unsigned base);
    busy_cnt_t len;
    if (collide) len = busy_cnt_t'(MAX_BUSY);
    else         len = busy_cnt_t'(base);
    return len;
  endfunction

endpackage

// File: rtl/hif_host_port.sv
module hif_host_port
  import hif_pkg::*;
#(
  parameter int unsigned HOST_BUSY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic collide,
  output logic wr_ready,
  output logic wr_take
);

  busy_cnt_t busy_q;
  busy_cnt_t busy_d;

  assign wr_ready = (busy_q == '0);
  assign wr_take  = wr_valid && wr_ready;

  always_comb begin
    busy_d = busy_q;
    if (wr_take)            busy_d = host_busy_len(collide, HOST_BUSY);
    else if (busy_q != '0)  busy_d = busy_q - busy_cnt_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_d;
  end

endmodule

// File: rtl/hif_cpu_port.sv
module hif_cpu_port (
  input  logic wr_valid,
  input  logic set_pending,
  output logic wr_ready,
  output logic wr_take
);

  // The CPU channel waits only while a deferred set is outstanding.
  assign wr_ready = !set_pending;
  assign wr_take  = wr_valid && wr_ready;

endmodule

// File: rtl/hif_flag_core.sv
module hif_flag_core
  import hif_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_take,
  input  logic host_bit,
  input  logic cpu_take,
  input  logic cpu_bit,
  output logic flag,
  output logic set_pending,
  output logic collide
);

  logic      clr_req;
  logic      set_req;
  flag_act_e act;
  logic      flag_d;
  logic      pend_d;

  assign clr_req = host_take && host_bit;
  assign set_req = (cpu_take && cpu_bit) || set_pending;
  assign collide = clr_req && cpu_take && cpu_bit;

  always_comb begin
    unique case ({clr_req, set_req})
      2'b11:   act = ACT_COLLIDE;
      2'b10:   act = ACT_CLEAR;
      2'b01:   act = ACT_SET;
      default: act = ACT_NONE;
    endcase
  end

  always_comb begin
    flag_d = flag;
    pend_d = 1'b0;
    unique case (act)
      ACT_SET:     flag_d = 1'b1;
      ACT_CLEAR:   flag_d = 1'b0;
      ACT_COLLIDE: begin
        // Clear wins now; the set is replayed on the following edge.
        flag_d = 1'b0;
        pend_d = 1'b1;
      end
      default:     flag_d = flag;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag        <= 1'b0;
      set_pending <= 1'b0;
    end else begin
      flag        <= flag_d;
      set_pending <= pend_d;
    end
  end

endmodule

// File: rtl/hif_flag_top.sv
module hif_flag_top
  import hif_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FLAG_BIT  = 3,
  parameter int unsigned HOST_BUSY = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_valid,
  input  logic [DATA_W-1:0] host_wr_data,
  output logic              host_wr_ready,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              cpu_wr_valid,
  input  logic [DATA_W-1:0] cpu_wr_data,
  output logic              cpu_wr_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              host_int_n
);

  logic host_take;
  logic cpu_take;
  logic flag;
  logic set_pending;
  logic collide;

  hif_host_port #(.HOST_BUSY(HOST_BUSY)) u_host (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (host_wr_valid),
    .collide  (collide),
    .wr_ready (host_wr_ready),
    .wr_take  (host_take)
  );

  hif_cpu_port u_cpu (
    .wr_valid    (cpu_wr_valid),
    .set_pending (set_pending),
    .wr_ready    (cpu_wr_ready),
    .wr_take     (cpu_take)
  );

  hif_flag_core u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_take   (host_take),
    .host_bit    (host_wr_data[FLAG_BIT]),
    .cpu_take    (cpu_take),
    .cpu_bit     (cpu_wr_data[FLAG_BIT]),
    .flag        (flag),
    .set_pending (set_pending),
    .collide     (collide)
  );

  // Read views: flag at its bit, zero elsewhere.
  for (genvar b = 0; b < DATA_W; b++) begin : g_rd
    if (b == FLAG_BIT) begin : g_flag
      assign host_rdata[b] = flag;
      assign cpu_rdata[b]  = flag;
    end else begin : g_zero
      assign host_rdata[b] = 1'b0;
      assign cpu_rdata[b]  = 1'b0;
    end
  end

  assign host_int_n = ~flag;

endmodule

// File: rtl/hif_flag_chk.sv
module hif_flag_chk #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FLAG_BIT  = 3,
  parameter int unsigned HOST_BUSY = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_valid,
  input logic [DATA_W-1:0] host_wr_data,
  input logic              host_wr_ready,
  input logic [DATA_W-1:0] host_rdata,
  input logic              cpu_wr_valid,
  input logic [DATA_W-1:0] cpu_wr_data,
  input logic              cpu_wr_ready,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              host_int_n
);

  logic h_clr;
  logic c_set;
  logic flg;
  logic [2:0] low_run;

  assign h_clr = host_wr_valid && host_wr_ready && host_wr_data[FLAG_BIT];
  assign c_set = cpu_wr_valid && cpu_wr_ready && cpu_wr_data[FLAG_BIT];
  assign flg   = cpu_rdata[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run <= '0;
    else if (host_wr_ready)  low_run <= '0;
    else if (low_run != 3'd7) low_run <= low_run + 3'd1;
  end

  initial begin
    AST_BUSY_PARAM: assert (HOST_BUSY >= 1 && HOST_BUSY <= 2); // R6
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (c_set && !h_clr) |=> flg); // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    h_clr |=> !flg); // R3

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_clr && !c_set && cpu_wr_ready) |=> $stable(flg)); // R4

  AST_COLLIDE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (h_clr && c_set) |=> (!flg && !cpu_wr_ready)); // R5

  AST_COLLIDE_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (h_clr && c_set) |-> ##2 (flg && cpu_wr_ready)); // R5

  AST_HOST_READY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 3'd2); // R6

  AST_INT_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    host_int_n == !flg); // R8

  AST_READ_VIEWS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata == cpu_rdata) && ($countones(cpu_rdata) <= 1)); // R9

endmodule

bind hif_flag_top hif_flag_chk #(
  .DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT), .HOST_BUSY(HOST_BUSY)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data),
  .host_wr_ready(host_wr_ready), .host_rdata(host_rdata),
  .cpu_wr_valid(cpu_wr_valid), .cpu_wr_data(cpu_wr_data),
  .cpu_wr_ready(cpu_wr_ready), .cpu_rdata(cpu_rdata),
  .host_int_n(host_int_n)
);

// File: tb/hif_flag_top_tb.sv
module hif_flag_top_tb;

  localparam int unsigned DW = 16;
  localparam int unsigned FB = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr_valid = 1'b0;
  logic [DW-1:0] host_wr_data = '0;
  logic          host_wr_ready;
  logic [DW-1:0] host_rdata;
  logic          cpu_wr_valid = 1'b0;
  logic [DW-1:0] cpu_wr_data = '0;
  logic          cpu_wr_ready;
  logic [DW-1:0] cpu_rdata;
  logic          host_int_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [DW-1:0] FMASK = DW'(1) << FB;

  always #5 clk = ~clk;

  hif_flag_top #(.DATA_W(DW), .FLAG_BIT(FB), .HOST_BUSY(1)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data),
    .host_wr_ready(host_wr_ready), .host_rdata(host_rdata),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_data(cpu_wr_data),
    .cpu_wr_ready(cpu_wr_ready), .cpu_rdata(cpu_rdata),
    .host_int_n(host_int_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Checks the flag through all three visible views.
  task automatic chk_flag(input string req, input logic exp);
    chk(req, "host_rdata", 32'(host_rdata), exp ? 32'(FMASK) : 32'd0);
    chk(req, "cpu_rdata", 32'(cpu_rdata), exp ? 32'(FMASK) : 32'd0);
    chk("R8", "host_int_n", 32'(host_int_n), 32'(!exp));
  endtask

  task automatic wait_host_idle();
    while (!host_wr_ready) @(negedge clk);
  endtask

  // Single write on one side; returns at the negedge after it is taken.
  task automatic host_write(input logic [DW-1:0] d);
    @(negedge clk);
    wait_host_idle();
    host_wr_valid = 1'b1; host_wr_data = d;
    @(negedge clk);
    host_wr_valid = 1'b0; host_wr_data = '0;
  endtask

  task automatic cpu_write(input logic [DW-1:0] d);
    @(negedge clk);
    while (!cpu_wr_ready) @(negedge clk);
    cpu_wr_valid = 1'b1; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr_valid = 1'b0; cpu_wr_data = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_flag("R1", 1'b0);
    chk("R1", "host_wr_ready", 32'(host_wr_ready), 32'd1);
    chk("R1", "cpu_wr_ready", 32'(cpu_wr_ready), 32'd1);
  endtask

  task automatic t_set_clear();
    cpu_write(FMASK);
    chk_flag("R2", 1'b1);
    host_write(FMASK | 16'h0001);
    chk_flag("R3", 1'b0);
    chk("R6", "host ready after plain write", 32'(host_wr_ready), 32'd0);
    @(negedge clk);
    chk("R6", "host ready back", 32'(host_wr_ready), 32'd1);
  endtask

  task automatic t_zero_and_redundant();
    cpu_write(~FMASK);
    chk_flag("R4", 1'b0);
    host_write(FMASK);            // clear while already clear
    chk_flag("R4", 1'b0);
    cpu_write(FMASK);
    cpu_write(FMASK);             // set while already set
    chk_flag("R4", 1'b1);
    host_write(~FMASK);
    chk_flag("R4", 1'b1);
  endtask

  task automatic t_collision(input logic start);
    if (start) cpu_write(FMASK); else host_write(FMASK);
    @(negedge clk);
    wait_host_idle();
    host_wr_valid = 1'b1; host_wr_data = FMASK;
    cpu_wr_valid  = 1'b1; cpu_wr_data  = FMASK;
    @(negedge clk);
    host_wr_valid = 1'b0; cpu_wr_valid = 1'b0;
    host_wr_data = '0; cpu_wr_data = '0;
    chk_flag("R5", 1'b0);
    chk("R5", "cpu ready in replay cycle", 32'(cpu_wr_ready), 32'd0);
    chk("R6", "host ready cycle 1", 32'(host_wr_ready), 32'd0);
    @(negedge clk);
    chk_flag("R5", 1'b1);
    chk("R5", "cpu ready after replay", 32'(cpu_wr_ready), 32'd1);
    chk("R6", "host ready cycle 2", 32'(host_wr_ready), 32'd0);
    @(negedge clk);
    chk("R6", "host ready cycle 3", 32'(host_wr_ready), 32'd1);
  endtask

  task automatic t_hold_while_busy();
    cpu_write(FMASK);
    host_write(16'h0000);          // taken, no clear; ready now low
    chk("R7", "host busy", 32'(host_wr_ready), 32'd0);
    host_wr_valid = 1'b1; host_wr_data = FMASK;
    @(negedge clk);
    chk_flag("R7", 1'b1);          // not taken while ready was low
    chk("R7", "host ready", 32'(host_wr_ready), 32'd1);
    @(negedge clk);
    host_wr_valid = 1'b0; host_wr_data = '0;
    chk_flag("R7", 1'b0);          // taken at the first ready edge
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_clear();
    t_zero_and_redundant();
    t_collision(1'b1);
    t_collision(1'b0);
    t_hold_while_busy();
    chk("R9", "read views equal", 32'(host_rdata ^ cpu_rdata), 32'd0);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule